// File: doc/BRIEF.md
# Command FIFO with Fence Status

This block is the host-facing command entry of an accelerator. The host writes 32-bit command words to a single push address, and they are queued in a FIFO. A downstream consumer takes them strictly in arrival order through a valid/ready handshake. Commands whose top nibble marks them as fences carry a 16-bit tag and an optional interrupt request. The fence takes effect only when the consumer takes it from the head of the queue, so the recorded tag always shows how far execution has really advanced through the stream. It never shows how far the host has written.

A second address returns a status word. It holds the queue occupancy, a busy indication, a sticky overflow flag, a fence-reached flag, an interrupt flag, the interrupt enable and the tag of the last fence retired. The three flags are cleared by writing ones to their bit positions. A third address holds the interrupt enable. The interrupt line is the interrupt flag gated by that enable.

Top module: `cmd_fence_fifo`

## Requirements
- R1: After reset the queue is empty (`cons_valid` low), every status flag, the fence tag, the interrupt enable, `irq_o` and `host_rdata` are all zero.
- R2: A write to address 0 enqueues `host_wdata`. `cons_valid` is high while the queue holds at least one word, and `cons_data` presents the words in the order they were written. A word leaves the queue on a clock edge where `cons_valid` and `cons_ready` are both high.
- R3: The queue holds `DEPTH` (default 16) words. A write to address 0 while the queue is full is discarded and sets the sticky overflow flag (status bit 9). The queued words are left unchanged.
- R4: Status (address 1) bits [4:0] give the number of queued words. Bit 8 (busy) is high when the queue is non-empty or `cons_busy` is high.
- R5: A word with bits [31:28] = 4'hF is a fence, and its bits [15:0] are its tag. Status bits [31:16] take that tag on the edge the fence is consumed. Enqueueing a fence leaves them unchanged.
- R6: Consuming a fence sets the fence-reached flag (status bit 10). If the fence's bit 16 is 1, it also sets the interrupt flag (status bit 11).
- R7: A write to address 1 clears each of status bits 9, 10 and 11 whose written bit is 1. All other written bits are ignored. If a set and a clear of the same flag fall on one edge, the set wins.
- R8: Bit 0 of address 2 is the interrupt enable. It can be written and read back, and it is mirrored in status bit 12. `irq_o` equals (interrupt flag AND enable) as they stood one cycle earlier.
- R9: `host_rdata` updates on the clock edge where `host_rd` is high, one cycle of latency. A read of address 0 returns zero.
- R10: Consuming a word that is not a fence leaves the tag, the fence-reached flag and the interrupt flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | 0 command push, 1 status, 2 interrupt enable |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| cons_valid | output | 1 | Queue head holds a command |
| cons_ready | input | 1 | Consumer takes the head word |
| cons_data | output | 32 | Command word at the queue head |
| cons_busy | input | 1 | Consumer is still working on a command |
| irq_o | output | 1 | Fence interrupt |

## Verification
The hardest situation to reach is a fence being consumed on the same edge that the host writes a one to clear the interrupt flag. The flag must survive, which needs the pop and the status write to be aligned to the same cycle. The bench arranges this by holding `cons_ready` and the status write together in one cycle while the fence sits at the head. The other hard case is a write landing on a completely full queue. The bench fills all sixteen entries with distinct words, pushes one more, and then drains the queue to show that the extra word never appeared.

// File: rtl/cfq_pkg.sv
package cfq_pkg;
  localparam int CMD_W       = 32;
  localparam int TAG_W       = 16;
  localparam int IRQ_REQ_BIT = 16;
  localparam logic [3:0] FENCE_OP = 4'hF;

  typedef enum logic [1:0] {
    REG_CMD  = 2'd0,
    REG_STAT = 2'd1,
    REG_CTRL = 2'd2,
    REG_RSVD = 2'd3
  } reg_sel_e;

  localparam int ST_BUSY  = 8;
  localparam int ST_OVF   = 9;
  localparam int ST_FENCE = 10;
  localparam int ST_IRQ   = 11;
  localparam int ST_IEN   = 12;
  localparam int ST_TAG   = 16;
endpackage

// File: rtl/cfq_fifo_store.sv
module cfq_fifo_store #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CNT_W-1:0] fill,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             push_ok, pop_ok;

  assign empty   = (fill == '0);
  assign full    = (fill == CNT_W'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/cfq_fence_tracker.sv
module cfq_fence_tracker
  import cfq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             retire,
  input  logic [3:0]       retire_op,
  input  logic             retire_irq_req,
  input  logic [TAG_W-1:0] retire_tag,
  input  logic             clr_fence,
  input  logic             clr_irq,
  input  logic             irq_en,
  output logic [TAG_W-1:0] last_tag,
  output logic             fence_flag,
  output logic             irq_flag,
  output logic             irq_o
);
  logic is_fence;
  assign is_fence = retire && (retire_op == FENCE_OP);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_tag   <= '0;
      fence_flag <= 1'b0;
      irq_flag   <= 1'b0;
      irq_o      <= 1'b0;
    end else begin
      if (is_fence) last_tag <= retire_tag;

      if (is_fence)       fence_flag <= 1'b1;
      else if (clr_fence) fence_flag <= 1'b0;

      if (is_fence && retire_irq_req) irq_flag <= 1'b1;
      else if (clr_irq)               irq_flag <= 1'b0;

      irq_o <= irq_flag && irq_en;
    end
  end
endmodule

// File: rtl/cfq_host_regs.sv
module cfq_host_regs
  import cfq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [1:0]       host_addr,
  input  logic             wbit_ovf,
  input  logic             wbit_fence,
  input  logic             wbit_irq,
  input  logic             wbit_ien,
  input  logic             drop_evt,
  input  logic [CMD_W-1:0] status_word,
  output logic             cmd_push,
  output logic             clr_fence,
  output logic             clr_irq,
  output logic             ovf_flag,
  output logic             irq_en,
  output logic [CMD_W-1:0] host_rdata
);
  reg_sel_e sel;
  logic     stat_wr, ctrl_wr;

  assign sel       = reg_sel_e'(host_addr);
  assign cmd_push  = host_wr && (sel == REG_CMD);
  assign stat_wr   = host_wr && (sel == REG_STAT);
  assign ctrl_wr   = host_wr && (sel == REG_CTRL);
  assign clr_fence = stat_wr && wbit_fence;
  assign clr_irq   = stat_wr && wbit_irq;

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag   <= 1'b0;
      irq_en     <= 1'b0;
      host_rdata <= '0;
    end else begin
      if (drop_evt)                  ovf_flag <= 1'b1;
      else if (stat_wr && wbit_ovf)  ovf_flag <= 1'b0;

      if (ctrl_wr) irq_en <= wbit_ien;

      if (host_rd) begin
        case (sel)
          REG_STAT: host_rdata <= status_word;
          REG_CTRL: host_rdata <= {{(CMD_W-1){1'b0}}, irq_en};
          default:  host_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmd_fence_fifo.sv
module cmd_fence_fifo
  import cfq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [1:0]       host_addr,
  input  logic [CMD_W-1:0] host_wdata,
  output logic [CMD_W-1:0] host_rdata,
  output logic             cons_valid,
  input  logic             cons_ready,
  output logic [CMD_W-1:0] cons_data,
  input  logic             cons_busy,
  output logic             irq_o
);
  logic [CNT_W-1:0] fill;
  logic             empty, full, cmd_push, pop_fire, drop_evt;
  logic             clr_fence, clr_irq, ovf_flag, irq_en, busy;
  logic             fence_flag, irq_flag;
  logic [TAG_W-1:0] last_tag;
  logic [CMD_W-1:0] status_word;

  cfq_fifo_store #(.WIDTH(CMD_W), .DEPTH(DEPTH)) store_i (
    .clk(clk), .rst(rst), .push(cmd_push), .wdata(host_wdata), .pop(cons_ready),
    .rdata(cons_data), .fill(fill), .empty(empty), .full(full)
  );

  assign cons_valid = !empty;
  assign pop_fire   = cons_valid && cons_ready;
  assign drop_evt   = cmd_push && full;
  assign busy       = !empty || cons_busy;

  cfq_fence_tracker fence_i (
    .clk(clk), .rst(rst), .retire(pop_fire),
    .retire_op(cons_data[31:28]), .retire_irq_req(cons_data[IRQ_REQ_BIT]),
    .retire_tag(cons_data[TAG_W-1:0]), .clr_fence(clr_fence), .clr_irq(clr_irq),
    .irq_en(irq_en), .last_tag(last_tag), .fence_flag(fence_flag),
    .irq_flag(irq_flag), .irq_o(irq_o)
  );

  always_comb begin
    status_word                 = '0;
    status_word[CNT_W-1:0]      = fill;
    status_word[ST_BUSY]        = busy;
    status_word[ST_OVF]         = ovf_flag;
    status_word[ST_FENCE]       = fence_flag;
    status_word[ST_IRQ]         = irq_flag;
    status_word[ST_IEN]         = irq_en;
    status_word[ST_TAG+:TAG_W]  = last_tag;
  end

  cfq_host_regs regs_i (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .wbit_ovf(host_wdata[ST_OVF]), .wbit_fence(host_wdata[ST_FENCE]),
    .wbit_irq(host_wdata[ST_IRQ]), .wbit_ien(host_wdata[0]),
    .drop_evt(drop_evt), .status_word(status_word), .cmd_push(cmd_push),
    .clr_fence(clr_fence), .clr_irq(clr_irq), .ovf_flag(ovf_flag),
    .irq_en(irq_en), .host_rdata(host_rdata)
  );
endmodule

// File: rtl/cmd_fence_fifo_chk.sv
module cmd_fence_fifo_chk
  import cfq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] fill,
  input logic             cons_valid,
  input logic             cons_ready,
  input logic [CMD_W-1:0] cons_data,
  input logic             cmd_push,
  input logic             full,
  input logic             ovf_flag,
  input logic [TAG_W-1:0] last_tag,
  input logic             irq_flag,
  input logic             irq_en,
  input logic             irq_o
);
  logic fence_pop;
  assign fence_pop = cons_valid && cons_ready && (cons_data[31:28] == FENCE_OP);

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
    fill <= CNT_W'(DEPTH)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (cmd_push && full) |=> ovf_flag); // R3
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (rst)
    (fill == '0) |-> !cons_valid); // R2
  AST_TAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fence_pop |=> $stable(last_tag)); // R5
  AST_FENCE_IRQ: assert property (@(posedge clk) disable iff (rst)
    (fence_pop && cons_data[IRQ_REQ_BIT]) |=> irq_flag); // R6
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (rst)
    irq_o == $past(irq_flag && irq_en)); // R8
endmodule

bind cmd_fence_fifo cmd_fence_fifo_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .fill(fill), .cons_valid(cons_valid), .cons_ready(cons_ready),
  .cons_data(cons_data), .cmd_push(cmd_push), .full(full), .ovf_flag(ovf_flag),
  .last_tag(last_tag), .irq_flag(irq_flag), .irq_en(irq_en), .irq_o(irq_o)
);

// File: tb/cmd_fence_fifo_tb_top.sv
module cmd_fence_fifo_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata, cons_data;
  logic        cons_valid, cons_ready = 1'b0, cons_busy = 1'b0, irq_o;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  cmd_fence_fifo dut_i (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .cons_valid(cons_valid),
    .cons_ready(cons_ready), .cons_data(cons_data), .cons_busy(cons_busy), .irq_o(irq_o)
  );

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_POP = 2'd2;
  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{OP_RD,  2'd1, 32'h0,         32'h0000_0000}, // R1 status after reset
    '{OP_WR,  2'd0, 32'h0000_1111, 32'h0},
    '{OP_WR,  2'd0, 32'hF001_ABCD, 32'h0},         // fence with irq request
    '{OP_WR,  2'd0, 32'h0000_2222, 32'h0},
    '{OP_RD,  2'd1, 32'h0,         32'h0000_0103}, // R4 fill 3 busy, R5 tag not on push
    '{OP_POP, 2'd0, 32'h0,         32'h0000_1111}, // R2
    '{OP_RD,  2'd1, 32'h0,         32'h0000_0102}, // R10
    '{OP_POP, 2'd0, 32'h0,         32'hF001_ABCD}, // R2
    '{OP_RD,  2'd1, 32'h0,         32'hABCD_0D01}, // R5 R6
    '{OP_WR,  2'd2, 32'h0000_0001, 32'h0},
    '{OP_RD,  2'd2, 32'h0,         32'h0000_0001}, // R8
    '{OP_RD,  2'd1, 32'h0,         32'hABCD_1D01}, // R8 mirror
    '{OP_WR,  2'd1, 32'h0000_0800, 32'h0},
    '{OP_RD,  2'd1, 32'h0,         32'hABCD_1501}, // R7
    '{OP_POP, 2'd0, 32'h0,         32'h0000_2222}, // R2
    '{OP_WR,  2'd0, 32'hF000_0042, 32'h0},
    '{OP_POP, 2'd0, 32'h0,         32'hF000_0042}, // R2
    '{OP_RD,  2'd1, 32'h0,         32'h0042_1400}, // R6 no irq request
    '{OP_WR,  2'd1, 32'hFFFF_FFFF, 32'h0},
    '{OP_RD,  2'd1, 32'h0,         32'h0042_1000}, // R7 other bits ignored
    '{OP_RD,  2'd0, 32'h0,         32'h0000_0000}  // R9
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [31:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [31:0] d);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic do_pop(input string req, input logic [31:0] exp);
    check(req, {31'b0, cons_valid}, 32'd1);
    check(req, cons_data, exp);
    cons_ready = 1'b1;
    @(negedge clk);
    cons_ready = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    @(negedge clk);
    do_reset();
    check("R1 rdata", host_rdata, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1 valid", {31'b0, cons_valid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_WR:  do_write(VEC[i].addr, VEC[i].data);
        OP_RD:  begin do_read(VEC[i].addr, rv); check($sformatf("R9 vec%0d", i), rv, VEC[i].exp); end
        default: do_pop($sformatf("R2 vec%0d", i), VEC[i].exp);
      endcase
    end

    // R3: fill completely, push one more, drain
    do_reset();
    for (int i = 0; i < 17; i++) do_write(2'd0, 32'h100 + i);
    do_read(2'd1, rv);
    check("R3 full status", rv, 32'h0000_0310);
    for (int i = 0; i < 16; i++) do_pop("R3 drain order", 32'h100 + i);
    check("R3 empty after drain", {31'b0, cons_valid}, 32'h0);
    do_read(2'd1, rv);
    check("R3 sticky overflow", rv, 32'h0000_0200);
    do_write(2'd1, 32'h0000_0200);
    do_read(2'd1, rv);
    check("R7 overflow cleared", rv, 32'h0);

    // R4: busy from consumer alone
    cons_busy = 1'b1;
    do_read(2'd1, rv);
    check("R4 busy from consumer", rv, 32'h0000_0100);
    cons_busy = 1'b0;

    // R7/R8: set and clear on same edge, set wins
    do_write(2'd2, 32'h1);
    do_write(2'd0, 32'hF001_0077);
    check("R2 fence at head", cons_data, 32'hF001_0077);
    cons_ready = 1'b1; host_wr = 1'b1; host_addr = 2'd1; host_wdata = 32'h0000_0C00;
    @(negedge clk);
    cons_ready = 1'b0; host_wr = 1'b0;
    check("R8 irq lags flag", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    check("R8 irq asserted", {31'b0, irq_o}, 32'h1);
    do_read(2'd1, rv);
    check("R7 set wins", rv, 32'h0077_1C00);
    do_write(2'd2, 32'h0);
    @(negedge clk);
    check("R8 irq masked", {31'b0, irq_o}, 32'h0);
    do_write(2'd2, 32'h1);
    @(negedge clk);
    check("R8 irq unmasked", {31'b0, irq_o}, 32'h1);
    do_write(2'd1, 32'h0000_0800);
    @(negedge clk);
    check("R8 irq cleared", {31'b0, irq_o}, 32'h0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule